// File: doc/BRIEF.md
# Register Access Error Monitor

This block sits beside a register bank and watches every access the bank decodes. The bank reports, for each access, whether the target was in a locked partition, whether the address was unmapped, and whether the initiator lacked the secure or privilege level needed. The monitor turns these flags into three sticky event bits. Each event has its own enable bit, and one interrupt line rises while any enabled event is pending.

Software reaches the monitor through eight word registers:

| Word | Purpose |
|------|---------|
| 0 | Raw event view |
| 1 | Masked view with write-one-to-clear |
| 2 | Enable set |
| 3 | Enable clear |
| 4 | Fault address |
| 5 | Fault kind |
| 6 | Fault attributes |
| 7 | Fault release |

The monitor also records the address, kind and attributes of the first faulting access. That record holds until software releases it, so a storm of later errors cannot hide the access that caused the first one.

Top module: `acc_err_mon`

## Requirements
- R1: After reset, all eight registers read zero and `irq` is low.
- R2: Event bit 2 (lock) sets on a cycle with `mon_valid`, `mon_write` and `mon_lock_err` all high. `mon_lock_err` on a read (`mon_write` low) has no effect.
- R3: Event bit 1 (unmapped address) sets on a valid access with `mon_addr_err` high. Event bit 0 (protection) sets on a valid access with `mon_prot_err` high. Nothing sets any bit while `mon_valid` is low.
- R4: Event bits stay set until a 1 is written at their position in word 1. Writing 0 there has no effect. An event in the same cycle as its clear leaves the bit set.
- R5: Word 0 reads the event bits in bits 2:0. Word 1 reads the event bits ANDed with the enables. Writes to word 0 have no effect.
- R6: Writing 1 to a bit of word 2 sets that enable, and writing 1 to a bit of word 3 clears it. Zeros leave the enable unchanged. Both words read the enables in bits 2:0.
- R7: `irq` is high exactly when some event bit and its enable are both set. It reflects a register update from the clock edge that made the update.
- R8: The first faulting access records three values. Word 4 holds its address. Word 5 bits 2:0 hold its event bits (2 lock, 1 address, 0 protection). Word 6 holds its attributes: bit 2 privilege, bit 1 secure, bit 0 write. Later faults do not change the record.
- R9: Writing a value with bit 0 set to word 7 zeroes words 4 to 6 and re-arms the capture. A write with bit 0 clear has no effect. A fault in the same cycle as the release is captured. Word 7 reads zero.
- R10: Fault capture and event setting do not depend on the enable bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mon_valid | input | 1 | An observed access completes this cycle |
| mon_write | input | 1 | Observed access is a write |
| mon_secure | input | 1 | Observed access is secure |
| mon_priv | input | 1 | Observed access is privileged |
| mon_addr | input | ADDR_W | Address of the observed access |
| mon_lock_err | input | 1 | Target lies in a locked partition |
| mon_addr_err | input | 1 | Target address is unmapped |
| mon_prot_err | input | 1 | Access lacks the required security or privilege level |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data for `cfg_addr` (combinational) |
| irq | output | 1 | Shared error interrupt |

## Verification
The assertions assume that the observer presents at most one access per cycle. They also assume that the error flags mean something only while `mon_valid` is high, and that each register write targets exactly one word, so an enable set and an enable clear never meet in one cycle. The stimulus drives a single access and a single register write per cycle at most. It raises error flags with `mon_valid` both high and low. It places event and clear writes in the same cycle on purpose, so the tie rules are exercised while the input assumptions still hold.

// File: rtl/amon_pkg.sv
package amon_pkg;
    localparam int EVT_N    = 3;
    localparam int REG_AW   = 3;
    localparam int EVT_PROT = 0;
    localparam int EVT_ADDR = 1;
    localparam int EVT_LOCK = 2;
    localparam int ATTR_N   = 3;

    typedef logic [EVT_N-1:0] evt_vec_t;

    typedef enum logic [REG_AW-1:0] {
        REG_RAW   = 3'd0,
        REG_STAT  = 3'd1,
        REG_ENSET = 3'd2,
        REG_ENCLR = 3'd3,
        REG_FADDR = 3'd4,
        REG_FKIND = 3'd5,
        REG_FATTR = 3'd6,
        REG_FREL  = 3'd7
    } reg_idx_e;

    typedef struct packed {
        evt_vec_t raw;
        evt_vec_t en;
    } evt_state_t;
endpackage

// File: rtl/amon_evt.sv
module amon_evt
    import amon_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  evt_vec_t            evt_in,
    input  logic                cfg_we,
    input  logic [REG_AW-1:0]   cfg_addr,
    input  evt_vec_t            wmask,
    output evt_vec_t            raw,
    output evt_vec_t            en,
    output logic                irq
);
    evt_state_t st_d, st_q;
    evt_vec_t   stat_clr;
    evt_vec_t   en_set;
    evt_vec_t   en_clr;

    always_comb begin
        stat_clr = '0;
        en_set   = '0;
        en_clr   = '0;
        if (cfg_we) begin
            case (reg_idx_e'(cfg_addr))
                REG_STAT:  stat_clr = wmask;
                REG_ENSET: en_set   = wmask;
                REG_ENCLR: en_clr   = wmask;
                default: ;
            endcase
        end
        st_d     = st_q;
        st_d.en  = (st_q.en | en_set) & ~en_clr;
        // a new event overrides a clear in the same cycle
        st_d.raw = (st_q.raw & ~stat_clr) | evt_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw = st_q.raw;
    assign en  = st_q.en;
    assign irq = |(st_q.raw & st_q.en);

    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(st_q.raw) & ~$past(stat_clr)) & ~st_q.raw) == '0)); // R4
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in != '0) |=> ((st_q.raw & $past(evt_in)) == $past(evt_in))); // R4
    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set != '0) |=> ((st_q.en & $past(en_set)) == $past(en_set))); // R6
    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr != '0) |=> ((st_q.en & $past(en_clr)) == '0)); // R6
endmodule

// File: rtl/amon_capt.sv
module amon_capt
    import amon_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  evt_vec_t            evt_in,
    input  logic [ADDR_W-1:0]   mon_addr,
    input  logic [ATTR_N-1:0]   attr_in,
    input  logic                release_req,
    output logic [ADDR_W-1:0]   f_addr,
    output evt_vec_t            f_kind,
    output logic [ATTR_N-1:0]   f_attr
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        evt_vec_t          kind;
        logic [ATTR_N-1:0] attr;
    } capt_t;

    capt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (release_req) c_d = '0;
        // kind of zero marks the record as empty and armed
        if ((evt_in != '0) && (c_d.kind == '0)) begin
            c_d.addr = mon_addr;
            c_d.kind = evt_in;
            c_d.attr = attr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign f_addr = c_q.addr;
    assign f_kind = c_q.kind;
    assign f_attr = c_q.attr;

    AST_CAPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.kind != '0) && !release_req) |=> ($stable(c_q.addr) && $stable(c_q.kind) && $stable(c_q.attr))); // R8
    AST_CAPT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.kind == '0) && (evt_in != '0)) |=> (c_q.kind == $past(evt_in))); // R8
    AST_CAPT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (release_req && (evt_in == '0)) |=> ((c_q.kind == '0) && (c_q.addr == '0) && (c_q.attr == '0))); // R9
endmodule

// File: rtl/amon_rdmux.sv
module amon_rdmux
    import amon_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic [REG_AW-1:0]   cfg_addr,
    input  evt_vec_t            raw,
    input  evt_vec_t            en,
    input  logic [ADDR_W-1:0]   f_addr,
    input  evt_vec_t            f_kind,
    input  logic [ATTR_N-1:0]   f_attr,
    output logic [DATA_W-1:0]   rdata
);
    always_comb begin
        rdata = '0;
        case (reg_idx_e'(cfg_addr))
            REG_RAW:   rdata[EVT_N-1:0]  = raw;
            REG_STAT:  rdata[EVT_N-1:0]  = raw & en;
            REG_ENSET: rdata[EVT_N-1:0]  = en;
            REG_ENCLR: rdata[EVT_N-1:0]  = en;
            REG_FADDR: rdata[ADDR_W-1:0] = f_addr;
            REG_FKIND: rdata[EVT_N-1:0]  = f_kind;
            REG_FATTR: rdata[ATTR_N-1:0] = f_attr;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/acc_err_mon.sv
module acc_err_mon
    import amon_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mon_valid,
    input  logic                mon_write,
    input  logic                mon_secure,
    input  logic                mon_priv,
    input  logic [ADDR_W-1:0]   mon_addr,
    input  logic                mon_lock_err,
    input  logic                mon_addr_err,
    input  logic                mon_prot_err,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic [DATA_W-1:0]   cfg_rdata,
    output logic                irq
);
    evt_vec_t          evt_in;
    evt_vec_t          raw;
    evt_vec_t          en;
    logic [ATTR_N-1:0] attr_in;
    logic              release_req;
    logic [ADDR_W-1:0] f_addr;
    evt_vec_t          f_kind;
    logic [ATTR_N-1:0] f_attr;

    always_comb begin
        evt_in = '0;
        if (mon_valid) begin
            evt_in[EVT_LOCK] = mon_lock_err & mon_write;
            evt_in[EVT_ADDR] = mon_addr_err;
            evt_in[EVT_PROT] = mon_prot_err;
        end
        attr_in     = {mon_priv, mon_secure, mon_write};
        release_req = cfg_we && (reg_idx_e'(cfg_addr) == REG_FREL) && cfg_wdata[0];
    end

    amon_evt u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (evt_in),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .wmask    (cfg_wdata[EVT_N-1:0]),
        .raw      (raw),
        .en       (en),
        .irq      (irq)
    );

    amon_capt #(.ADDR_W(ADDR_W)) u_capt (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_in      (evt_in),
        .mon_addr    (mon_addr),
        .attr_in     (attr_in),
        .release_req (release_req),
        .f_addr      (f_addr),
        .f_kind      (f_kind),
        .f_attr      (f_attr)
    );

    amon_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .cfg_addr (cfg_addr),
        .raw      (raw),
        .en       (en),
        .f_addr   (f_addr),
        .f_kind   (f_kind),
        .f_attr   (f_attr),
        .rdata    (cfg_rdata)
    );

    AST_LOCK_RD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_valid && !mon_write && !raw[EVT_LOCK]) |=> !raw[EVT_LOCK]); // R2
    AST_ADDR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_valid && mon_addr_err) |=> raw[EVT_ADDR]); // R3
    AST_IDLE_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_valid && (raw == '0)) |=> (raw == '0)); // R3
    AST_IRQ_OFF_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (reg_idx_e'(cfg_addr) == REG_ENCLR) && (&cfg_wdata[EVT_N-1:0])) |=> !irq); // R7
    AST_CAPT_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ((f_kind == '0) && mon_valid && mon_prot_err && !release_req) |=> (f_kind != '0)); // R10
endmodule

// File: tb/sim_acc_err_mon.sv
module sim_acc_err_mon;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mon_valid = 1'b0, mon_write = 1'b0, mon_secure = 1'b0, mon_priv = 1'b0;
    logic [31:0] mon_addr = '0;
    logic        mon_lock_err = 1'b0, mon_addr_err = 1'b0, mon_prot_err = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    acc_err_mon u0 (
        .clk(clk), .rst_n(rst_n),
        .mon_valid(mon_valid), .mon_write(mon_write), .mon_secure(mon_secure),
        .mon_priv(mon_priv), .mon_addr(mon_addr),
        .mon_lock_err(mon_lock_err), .mon_addr_err(mon_addr_err), .mon_prot_err(mon_prot_err),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq(irq)
    );

    // behavioural reference
    logic [2:0]  m_raw, m_en, m_kind, m_attr;
    logic [31:0] m_faddr;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_raw = 0; m_en = 0; m_kind = 0; m_attr = 0; m_faddr = 0;
        end else begin
            logic [2:0] ev;
            ev = 3'b000;
            if (mon_valid) ev = {mon_lock_err && mon_write, mon_addr_err, mon_prot_err};
            if (cfg_we) begin
                if (cfg_addr == 3'd1) m_raw = m_raw & ~cfg_wdata[2:0];
                if (cfg_addr == 3'd2) m_en = m_en | cfg_wdata[2:0];
                if (cfg_addr == 3'd3) m_en = m_en & ~cfg_wdata[2:0];
                if (cfg_addr == 3'd7 && cfg_wdata[0]) begin
                    m_kind = 0; m_attr = 0; m_faddr = 0;
                end
            end
            m_raw = m_raw | ev;
            if (ev != 0 && m_kind == 0) begin
                m_kind = ev; m_faddr = mon_addr; m_attr = {mon_priv, mon_secure, mon_write};
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {29'd0, m_raw};
            3'd1: return {29'd0, m_raw & m_en};
            3'd2, 3'd3: return {29'd0, m_en};
            3'd4: return m_faddr;
            3'd5: return {29'd0, m_kind};
            3'd6: return {29'd0, m_attr};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2, 3'd3: return "R6";
            3'd7: return "R9";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        chk({31'd0, irq}, {31'd0, |(m_raw & m_en)}, "R7");
        chk(cfg_rdata, m_read(cfg_addr), tag_of(cfg_addr));
    endtask

    task automatic idle();
        mon_valid = 0; mon_write = 0; mon_secure = 0; mon_priv = 0;
        mon_lock_err = 0; mon_addr_err = 0; mon_prot_err = 0; cfg_we = 0; cfg_wdata = 0;
    endtask

    task automatic acc(input logic v, input logic w, input logic s, input logic p,
                       input logic [31:0] a, input logic le, input logic ae, input logic pe);
        mon_valid = v; mon_write = w; mon_secure = s; mon_priv = p; mon_addr = a;
        mon_lock_err = le; mon_addr_err = ae; mon_prot_err = pe;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    endtask

    task automatic expect_rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        idle();
        cfg_addr = a;
        tick();
        chk(cfg_rdata, exp, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        for (int i = 0; i < 8; i++) expect_rd(3'(i), 32'd0, "R1");
        chk({31'd0, irq}, 32'd0, "R1");

        // R2: lock flag on a read is ignored
        idle(); acc(1, 0, 1, 1, 32'h10, 1, 0, 0); tick();
        expect_rd(0, 32'd0, "R2");
        // R3: flags without valid are ignored
        idle(); acc(0, 1, 0, 0, 32'h20, 1, 1, 1); tick();
        expect_rd(0, 32'd0, "R3");
        expect_rd(5, 32'd0, "R3");

        // R2/R8/R10: locked write captured with enables off
        idle(); acc(1, 1, 1, 0, 32'h1234, 1, 0, 0); tick();
        expect_rd(0, 32'd4, "R2");
        expect_rd(5, 32'd4, "R8");
        expect_rd(6, 32'd3, "R8");
        expect_rd(4, 32'h1234, "R10");
        chk({31'd0, irq}, 32'd0, "R10");

        // R3/R8: later fault does not overwrite
        idle(); acc(1, 0, 0, 1, 32'h55, 0, 1, 0); tick();
        expect_rd(0, 32'd6, "R3");
        expect_rd(4, 32'h1234, "R8");

        // R6/R7/R5
        idle(); wr(2, 32'h2); tick();
        chk({31'd0, irq}, 32'd1, "R7");
        expect_rd(1, 32'd2, "R5");
        idle(); wr(0, 32'h7); tick();
        expect_rd(0, 32'd6, "R5");

        // R4: zero write, clear colliding with event, plain clear
        idle(); wr(1, 32'h0); tick();
        expect_rd(0, 32'd6, "R4");
        idle(); wr(1, 32'h2); acc(1, 1, 0, 0, 32'h66, 0, 1, 0); tick();
        expect_rd(0, 32'd6, "R4");
        idle(); wr(1, 32'h2); tick();
        expect_rd(0, 32'd4, "R4");
        chk({31'd0, irq}, 32'd0, "R7");

        // R6: zero write, set, clear all
        idle(); wr(3, 32'h0); tick();
        expect_rd(2, 32'd2, "R6");
        idle(); wr(2, 32'h5); tick();
        expect_rd(3, 32'd7, "R6");
        chk({31'd0, irq}, 32'd1, "R7");
        idle(); wr(3, 32'h7); tick();
        chk({31'd0, irq}, 32'd0, "R7");

        // R9: release behaviour
        idle(); wr(7, 32'hFFFE); tick();
        expect_rd(4, 32'h1234, "R9");
        idle(); wr(7, 32'h1); tick();
        expect_rd(4, 32'd0, "R9");
        expect_rd(5, 32'd0, "R9");
        idle(); wr(7, 32'h1); acc(1, 0, 0, 0, 32'h77, 0, 0, 1); tick();
        expect_rd(5, 32'd1, "R9");
        expect_rd(4, 32'h77, "R9");
        expect_rd(6, 32'd0, "R9");
        expect_rd(7, 32'd0, "R9");

        // mixed traffic compared every cycle against the reference
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom;
            idle();
            acc(r[1:0] == 2'b00, r[2], r[3], r[4], $urandom, r[7:5] == 3'b000,
                r[10:8] == 3'b000, r[13:11] == 3'b000);
            cfg_addr = r[16:14];
            if (r[18:17] == 2'b00) wr(r[21:19], {29'd0, r[24:22]});
            tick();
        end

        idle(); tick();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule